// File: doc/BRIEF.md
# Fractional Audio Master-Clock Divider

This block derives an audio master clock from a fast, fixed-rate source clock, typically 160 MHz for an MCLK of 256 times the sample rate. Each MCLK period lasts either N or N+1 source cycles. An integer divider N sets the base length. A numerator/denominator fraction decides how many periods in a window get the extra cycle. The block turns the raw fraction into a compact dither code (group length, spread count, window size and a polarity bit) and uses that code to choose the long and short periods.

The code describes a window of `z` groups. Each group holds `x+1` periods, and an accumulator that steps by `y` modulo `z` lengthens `y` of the groups by one more period. The first period of every group is "marked". With polarity 0 the marked periods are the long ones. With polarity 1 every period except the marked ones is long. Either way, a window of `den` periods gets exactly `num` extra source cycles. The outputs are a one-cycle tick at the start of each MCLK period and a square-ish MCLK level. A new configuration is captured on an update strobe and takes effect only at a period boundary, so no runt pulse is produced.

Top module: `mclk_frac_div`

## Requirements
- R1: After reset, and on every cycle while `en` is low, `mclk_tick` and `mclk_out` are 0. In the source cycle that follows the first rising clock edge with `en` high, `mclk_tick` is 1, and a new dither window starts there.
- R2: When `frac_num` is 0 or `frac_den` is 0, every MCLK period lasts exactly N = `int_div` source cycles.
- R3: When 0 < `frac_num` <= `frac_den`/2 (integer division), each period lasts N or N+1 cycles. The first `frac_den` periods of a window total `frac_den`*N + `frac_num` cycles. The code used is z=num, x=den/num-1, y=den mod num, polarity 0.
- R4: When `frac_num` > `frac_den`/2 and the near-one rule does not apply, the complementary code is used: z=den-num, x=den/z-1, y=den mod z, polarity 1. The same window total as in R3 holds, and each period lasts N or N+1 cycles.
- R5: When `frac_num`*126 > `frac_den`*125, with `frac_den` nonzero, the fraction is dropped and every period lasts N+1 cycles.
- R6: `mclk_tick` is high for exactly the first source cycle of each period. In a period of L cycles, `mclk_out` is high for the first floor(L/2) cycles and low for the rest.
- R7: `int_div`, `frac_num` and `frac_den` are sampled when `upd` is high. The period in progress keeps its length, and the new setting applies from the next period, which also starts a new window. A setting captured while `en` is low is in force at the next enable.
- R8: Dropping `en` clears the period and dither state. On re-enable the window restarts from its beginning.
- R9: Changing `int_div`, `frac_num` or `frac_den` without an `upd` pulse has no effect on the period lengths.
- R10: An `int_div` value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider idle and MCLK low |
| upd | input | 1 | Strobe that captures the three configuration inputs |
| int_div | input | DIV_W | Integer divider N |
| frac_num | input | DIV_W | Fraction numerator |
| frac_den | input | DIV_W | Fraction denominator |
| mclk_tick | output | 1 | One-cycle pulse at the start of each MCLK period |
| mclk_out | output | 1 | MCLK level, high for the first half of each period |

## Verification
The bench builds the block with the default 9-bit divider fields and a reset divider of 4. This makes denominators up to 511 legal, so the 125/126 and 126/127 boundary of the near-one rule can be reached directly. Small values of N (1 to 8) keep each window short, so every period in a full window of up to 126 periods can be measured one by one. Fractions on both sides of den/2, including the exact half, exercise both code polarities.

// File: rtl/mclk_frac_pkg.sv
`timescale 1ns/1ps
package mclk_frac_pkg;

  localparam int unsigned CODE_FW = 16;

  typedef struct packed {
    logic [CODE_FW-1:0] div;
    logic [CODE_FW-1:0] x;
    logic [CODE_FW-1:0] y;
    logic [CODE_FW-1:0] z;
    logic               yn1;
  } frac_code_t;

  // Turns N and num/den into the dither code; bench restates it as totals.
  function automatic frac_code_t frac_encode(input int unsigned n_int,
                                             input int unsigned num,
                                             input int unsigned den);
    frac_code_t  c;
    int unsigned base;
    int unsigned gap;
    c    = '0;
    base = (n_int < 2) ? 2 : n_int;
    c.div = CODE_FW'(base);
    if (num == 0 || den == 0) begin
      c.yn1 = 1'b1;
    end else if (num * 126 > den * 125) begin
      c.yn1 = 1'b1;
      c.div = CODE_FW'(base + 1);
    end else if (num > den / 2) begin
      gap   = den - num;
      c.z   = CODE_FW'(gap);
      c.x   = CODE_FW'(den / gap - 1);
      c.y   = CODE_FW'(den % gap);
      c.yn1 = 1'b1;
    end else begin
      c.z   = CODE_FW'(num);
      c.x   = CODE_FW'(den / num - 1);
      c.y   = CODE_FW'(den % num);
      c.yn1 = 1'b0;
    end
    return c;
  endfunction

endpackage

// File: rtl/mclk_frac_encode.sv
`timescale 1ns/1ps
module mclk_frac_encode
  import mclk_frac_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] n_in,
  input  logic [DIV_W-1:0] num_in,
  input  logic [DIV_W-1:0] den_in,
  output logic [DIV_W:0]   div_o,
  output logic [DIV_W-1:0] x_o,
  output logic [DIV_W-1:0] y_o,
  output logic [DIV_W-1:0] z_o,
  output logic             yn1_o
);

  frac_code_t code;
  logic       spill;

  always_comb begin
    code  = frac_encode(32'(n_in), 32'(num_in), 32'(den_in));
    div_o = code.div[DIV_W:0];
    x_o   = code.x[DIV_W-1:0];
    y_o   = code.y[DIV_W-1:0];
    z_o   = code.z[DIV_W-1:0];
    yn1_o = code.yn1;
  end

  // Bits of the wide code that the narrow fields would lose.
  assign spill = (|(code.div >> (DIV_W + 1))) | (|(code.x >> DIV_W)) |
                 (|(code.y >> DIV_W)) | (|(code.z >> DIV_W));

  // R3/R4: the code always fits the divider field width
  p_code_fits_r3: assert property (@(posedge clk) disable iff (!rst_n) !spill);

endmodule

// File: rtl/mclk_cfg_shadow.sv
`timescale 1ns/1ps
module mclk_cfg_shadow #(
  parameter int              CW      = 38,
  parameter logic [CW-1:0]   RST_CFG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          upd,
  input  logic          period_end,
  input  logic [CW-1:0] cfg_in,
  output logic [CW-1:0] cfg_use,
  output logic          apply
);

  logic [CW-1:0] staged;
  logic [CW-1:0] active;
  logic          pend;

  // A staged setting moves in only at a period edge or while idle.
  assign apply   = pend && (!en || period_end);
  assign cfg_use = apply ? staged : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= RST_CFG;
      active <= RST_CFG;
      pend   <= 1'b0;
    end else begin
      if (apply) active <= staged;
      if (upd) begin
        staged <= cfg_in;
        pend   <= 1'b1;
      end else if (apply) begin
        pend <= 1'b0;
      end
    end
  end

  // R7: mid-period the active setting does not move
  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_end) |=> $stable(active));

  // R9: without a strobe the staged copy ignores the inputs
  p_staged_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(staged));

endmodule

// File: rtl/mclk_dither.sv
`timescale 1ns/1ps
module mclk_dither #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W:0]   div,
  input  logic [DIV_W-1:0] x,
  input  logic [DIV_W-1:0] y,
  input  logic [DIV_W-1:0] z,
  input  logic             yn1,
  output logic             period_end,
  output logic             tick,
  output logic             mclk
);

  localparam int CNT_W = DIV_W + 1;

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] gpos;
  logic [CNT_W-1:0] grp_last_q;
  logic [DIV_W-1:0] acc;

  logic             load;
  logic             new_win;
  logic             grp_new;
  logic [DIV_W:0]   sum;
  logic             ext;
  logic [DIV_W:0]   sum_wrap;
  logic             long_p;
  logic [CNT_W-1:0] plen;

  assign period_end = run && (cnt == last_q);
  assign load       = en && (!run || period_end);
  assign new_win    = !run || restart;
  assign grp_new    = new_win || (gpos == grp_last_q);

  // Group-level spread: accumulator steps by y modulo z.
  assign sum      = (new_win ? {(DIV_W+1){1'b0}} : {1'b0, acc}) + {1'b0, y};
  assign ext      = (z != '0) && (sum >= {1'b0, z});
  assign sum_wrap = ext ? (sum - {1'b0, z}) : sum;

  // Marked period is the first of a group; polarity picks long ones.
  assign long_p = yn1 ^ grp_new;
  assign plen   = div + CNT_W'(long_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      cnt        <= '0;
      last_q     <= '0;
      half_q     <= '0;
      gpos       <= '0;
      grp_last_q <= '0;
      acc        <= '0;
    end else if (!en) begin
      run        <= 1'b0;
      cnt        <= '0;
      last_q     <= '0;
      half_q     <= '0;
      gpos       <= '0;
      grp_last_q <= '0;
      acc        <= '0;
    end else if (load) begin
      run    <= 1'b1;
      cnt    <= '0;
      last_q <= plen - CNT_W'(1);
      half_q <= plen >> 1;
      if (grp_new) begin
        gpos       <= '0;
        grp_last_q <= {1'b0, x} + CNT_W'(ext);
        acc        <= sum_wrap[DIV_W-1:0];
      end else begin
        gpos <= gpos + CNT_W'(1);
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign tick = run && (cnt == '0);
  assign mclk = run && (cnt < half_q);

  // R1/R8: idle means no tick and a low clock
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick && !mclk));

  // R6: a tick never lasts two cycles
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6: a period opens with the clock high
  p_tick_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> mclk);

  // R3: spread accumulator stays below the window size
  p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && z != '0 && !restart) |-> ({1'b0, acc} < {1'b0, z}));

endmodule

// File: rtl/mclk_frac_div.sv
`timescale 1ns/1ps
module mclk_frac_div #(
  parameter int DIV_W     = 9,
  parameter int RESET_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             upd,
  input  logic [DIV_W-1:0] int_div,
  input  logic [DIV_W-1:0] frac_num,
  input  logic [DIV_W-1:0] frac_den,
  output logic             mclk_tick,
  output logic             mclk_out
);

  localparam int            CW      = (DIV_W + 1) + 3 * DIV_W + 1;
  localparam logic [CW-1:0] RST_CFG = {(DIV_W+1)'(RESET_DIV), {(3*DIV_W){1'b0}}, 1'b1};

  logic [DIV_W:0]   enc_div;
  logic [DIV_W-1:0] enc_x, enc_y, enc_z;
  logic             enc_yn1;
  logic [CW-1:0]    cfg_use;
  logic             apply;
  logic             period_end;

  mclk_frac_encode #(.DIV_W(DIV_W)) i_encode (
    .clk    (clk),
    .rst_n  (rst_n),
    .n_in   (int_div),
    .num_in (frac_num),
    .den_in (frac_den),
    .div_o  (enc_div),
    .x_o    (enc_x),
    .y_o    (enc_y),
    .z_o    (enc_z),
    .yn1_o  (enc_yn1)
  );

  mclk_cfg_shadow #(.CW(CW), .RST_CFG(RST_CFG)) i_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .upd        (upd),
    .period_end (period_end),
    .cfg_in     ({enc_div, enc_x, enc_y, enc_z, enc_yn1}),
    .cfg_use    (cfg_use),
    .apply      (apply)
  );

  mclk_dither #(.DIV_W(DIV_W)) i_dither (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .restart    (apply),
    .div        (cfg_use[CW-1 -: DIV_W+1]),
    .x          (cfg_use[3*DIV_W -: DIV_W]),
    .y          (cfg_use[2*DIV_W -: DIV_W]),
    .z          (cfg_use[DIV_W -: DIV_W]),
    .yn1        (cfg_use[0]),
    .period_end (period_end),
    .tick       (mclk_tick),
    .mclk       (mclk_out)
  );

  // R3/R4: a fractional code spans exactly den periods per window
  p_code_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && enc_z != '0) |->
      (32'(enc_z) * (32'(enc_x) + 1) + 32'(enc_y) == 32'(frac_den)));

endmodule

// File: tb/test_mclk_frac_div.sv
`timescale 1ns/1ps
module test_mclk_frac_div;

  localparam int DIV_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic upd = 1'b0;
  logic [DIV_W-1:0] int_div = 4;
  logic [DIV_W-1:0] frac_num = 0;
  logic [DIV_W-1:0] frac_den = 0;
  logic mclk_tick, mclk_out;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mclk_frac_div #(.DIV_W(DIV_W), .RESET_DIV(4)) i_mclk_frac_div (
    .clk(clk), .rst_n(rst_n), .en(en), .upd(upd),
    .int_div(int_div), .frac_num(frac_num), .frac_den(frac_den),
    .mclk_tick(mclk_tick), .mclk_out(mclk_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Positioned on a tick cycle; counts until the next tick.
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      len++;
      if (mclk_out) hi++;
      @(negedge clk);
    end while (!mclk_tick && len < 3000);
  endtask

  task automatic program_cfg(input int n, input int num, input int den, input string tag);
    @(negedge clk);
    en = 1'b0; int_div = DIV_W'(n); frac_num = DIV_W'(num); frac_den = DIV_W'(den);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (2) @(negedge clk);
    check(!mclk_tick && !mclk_out, {tag, " R1 idle"}, int'(mclk_tick | mclk_out), 0);
    en = 1'b1;
    @(negedge clk);
    check(mclk_tick == 1'b1, {tag, " R1 first tick"}, int'(mclk_tick), 1);
  endtask

  task automatic run_window(input string tag, input int n, input int num, input int den,
                            input int periods, input int exp_total, input int lo, input int hi_len);
    int total, len, h, bad_len, bad_hi;
    program_cfg(n, num, den, tag);
    total = 0; bad_len = 0; bad_hi = 0;
    for (int i = 0; i < periods; i++) begin
      measure(len, h);
      total += len;
      if (len < lo || len > hi_len) bad_len = len;
      if (h != len / 2) bad_hi = h + 1000 * len;
    end
    check(total == exp_total, {tag, " window total"}, total, exp_total);
    check(bad_len == 0, {tag, " period length range"}, bad_len, 0);
    check(bad_hi == 0, {tag, " R6 high half"}, bad_hi, 0);
  endtask

  // R7 and R9: strobe mid-period, then inputs changed without strobe
  task automatic test_update;
    int len, h;
    program_cfg(4, 0, 0, "R7");
    measure(len, h);
    check(len == 4, "R7 before update", len, 4);
    int_div = 8; upd = 1'b1;
    len = 1;
    @(negedge clk);
    upd = 1'b0;
    while (!mclk_tick && len < 3000) begin len++; @(negedge clk); end
    check(len == 4, "R7 period in progress keeps length", len, 4);
    measure(len, h);
    check(len == 8, "R7 new length after boundary", len, 8);
    int_div = 3; frac_num = 1; frac_den = 2;
    for (int i = 0; i < 3; i++) begin
      measure(len, h);
      check(len == 8, "R9 no strobe no effect", len, 8);
    end
  endtask

  // R8: disable mid-run, then re-enable restarts the window
  task automatic test_disable;
    int len, h, total;
    program_cfg(4, 3, 10, "R8");
    for (int i = 0; i < 4; i++) measure(len, h);
    @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!mclk_tick && !mclk_out, "R8 idle while disabled", int'(mclk_tick | mclk_out), 0);
    end
    en = 1'b1;
    @(negedge clk);
    check(mclk_tick == 1'b1, "R8 restart tick", int'(mclk_tick), 1);
    total = 0;
    for (int i = 0; i < 10; i++) begin measure(len, h); total += len; end
    check(total == 43, "R8 fresh window total", total, 43);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!mclk_tick && !mclk_out, "R1 in reset", int'(mclk_tick | mclk_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mclk_tick && !mclk_out, "R1 after reset", int'(mclk_tick | mclk_out), 0);

    run_window("R2 num zero",   4,   0,  10,  10,  40, 4, 4);
    run_window("R2 den zero",   5,   3,   0,   6,  30, 5, 5);
    run_window("R3 3/10",       4,   3,  10,  10,  43, 4, 5);
    run_window("R3 1/7",        5,   1,   7,   7,  36, 5, 6);
    run_window("R3 half 5/10",  6,   5,  10,  10,  65, 6, 7);
    run_window("R4 7/10",       4,   7,  10,  10,  47, 4, 5);
    run_window("R4 2/3",        2,   2,   3,   3,   8, 2, 3);
    run_window("R4 125/126",    3, 125, 126, 126, 503, 3, 4);
    run_window("R5 126/127",    3, 126, 127,  20,  80, 4, 4);
    run_window("R5 9/9",        6,   9,   9,   5,  35, 7, 7);
    run_window("R10 div one",   1,   0,   0,   4,   8, 2, 2);
    run_window("R10 div zero",  0,   0,   0,   3,   6, 2, 2);
    test_update();
    test_disable();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule